// File: doc/BRIEF.md
# Associative Page Translation Cache with Access Rights

This block keeps a small set of recently used virtual-to-physical page mappings and answers translation requests against all of them at once. A request carries a 32-bit virtual address and an access kind. The upper 21 bits of the address are the virtual page number and the low 11 bits are the byte offset within a 2 KB page. One clock later the block reports one of four outcomes. A hit comes with a 24-bit physical address. The other outcomes are a miss, a page fault (the mapping is cached but marked not resident) and a rights violation.

Each slot stores a page number tag, a 13-bit physical page number and four flag bits: resident, readable, writable and executable. An external walker installs mappings through a fill port. The page-fault handler can drop one mapping by page number, or drop every mapping in a single cycle. A fill for a page number already cached rewrites that slot. A fill for a new page number takes the lowest-numbered empty slot. When no slot is empty, the fill replaces the slot named by a rotating victim pointer.

Top module: `xlate_cache`

## Requirements
- R1: After reset no slot holds a mapping: every lookup reports a miss, and with no request pending all result outputs are low.
- R2: A lookup accepted on a rising edge (lk_valid high) is answered at the next edge with rsp_valid high and exactly one of hit, miss, page_fault, perm_fault high. When rsp_valid is low all four are low. paddr is zero unless hit is high.
- R3: A lookup whose page number matches no occupied slot reports miss.
- R4: A lookup that matches a slot whose resident flag (fill_flags bit 3) is clear reports page_fault for every access kind.
- R5: A lookup that matches a resident slot reports hit with paddr = {stored physical page, address bits 10:0} when the kind is permitted: kind 0 (read) needs bit 2, kind 1 (write) needs bit 1, kind 2 (execute) needs bit 0. Kind 3 is reserved and is never permitted. Otherwise it reports perm_fault.
- R6: A fill whose page number is already cached rewrites that slot's physical page and flags, leaves every other slot intact and does not move the victim pointer.
- R7: A fill of a new page number goes to the lowest-numbered empty slot when one exists, and the victim pointer does not move.
- R8: A fill of a new page number when all 16 slots are occupied replaces the slot at the victim pointer. The pointer starts at slot 0 after reset and advances by one, modulo 16, only on such a replacement.
- R9: inv_en removes the slot whose page number equals inv_vpn. Other slots are untouched, and a page number that is not cached changes nothing.
- R10: flush_all empties every slot in one cycle.
- R11: A fill presented in a cycle where inv_en or flush_all is high is discarded.
- R12: A lookup sees the slot contents as they were before any fill, invalidate or flush applied at the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_kind | input | 2 | Access kind: 0 read, 1 write, 2 execute, 3 reserved |
| fill_en | input | 1 | Install a mapping |
| fill_vpn | input | 21 | Virtual page number of the mapping |
| fill_ppn | input | 13 | Physical page number of the mapping |
| fill_flags | input | 4 | {resident, readable, writable, executable} |
| inv_en | input | 1 | Remove the mapping for inv_vpn |
| inv_vpn | input | 21 | Page number to remove |
| flush_all | input | 1 | Remove every mapping |
| rsp_valid | output | 1 | Result present for the previous cycle's lookup |
| hit | output | 1 | Translation succeeded |
| miss | output | 1 | No cached mapping |
| page_fault | output | 1 | Mapping cached but not resident |
| perm_fault | output | 1 | Access kind not permitted |
| paddr | output | 24 | Physical address on a hit, zero otherwise |

## Verification
A wrong occupancy bit or tag shows up at the ports on the first lookup that names the affected page: a cached page reports miss when it should not, or an evicted page still hits. This is visible one cycle after the request. A victim pointer that steps at the wrong time does no harm until the array is full. It is then exposed by the next replacing fill, because the wrong resident page disappears. For that reason the sweeps fill the array completely, evict, punch holes and refill, and then probe neighbouring pages. The flag logic is swept over every flag pattern crossed with every access kind.

// File: rtl/xlate_pkg.sv
package xlate_pkg;
  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_EXEC  = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_kind_e;

  typedef struct packed {
    logic v;
    logic r;
    logic w;
    logic x;
  } pte_flags_t;

  function automatic logic kind_allowed(pte_flags_t f, acc_kind_e k);
    case (k)
      ACC_READ:  return f.r;
      ACC_WRITE: return f.w;
      ACC_EXEC:  return f.x;
      default:   return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/xlate_store.sv
module xlate_store
  import xlate_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int VPN_W   = 21,
  parameter int PPN_W   = 13,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               flush,
  input  logic               inv_en,
  input  logic [VPN_W-1:0]   inv_vpn,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic [VPN_W-1:0]   wr_vpn,
  input  logic [PPN_W-1:0]   wr_ppn,
  input  pte_flags_t         wr_flags,
  input  logic [VPN_W-1:0]   lk_vpn,
  output logic [ENTRIES-1:0] present_o,
  output logic [ENTRIES-1:0] lk_match,
  output logic [ENTRIES-1:0] fill_match,
  output logic [PPN_W-1:0]   lk_ppn,
  output pte_flags_t         lk_flags
);
  logic [PPN_W-1:0] ppn_m [ENTRIES];
  logic [3:0]       flg_m [ENTRIES];
  logic [ENTRIES-1:0] inv_hits;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
    logic             pres_q;
    logic [VPN_W-1:0] tag_q;
    logic [PPN_W-1:0] ppn_q;
    pte_flags_t       flg_q;
    logic             sel;

    assign sel           = wr_en && (wr_idx == IDX_W'(g));
    assign present_o[g]  = pres_q;
    assign lk_match[g]   = pres_q && (tag_q == lk_vpn);
    assign fill_match[g] = pres_q && (tag_q == wr_vpn);
    assign inv_hits[g]   = pres_q && (tag_q == inv_vpn);
    assign ppn_m[g]      = lk_match[g] ? ppn_q : '0;
    assign flg_m[g]      = lk_match[g] ? flg_q : '0;

    always_ff @(posedge clk) begin
      if (rst)                       pres_q <= 1'b0;
      else if (flush)                pres_q <= 1'b0;
      else if (inv_en && inv_hits[g]) pres_q <= 1'b0;
      else if (sel)                  pres_q <= 1'b1;
    end

    always_ff @(posedge clk) begin
      if (sel) begin
        tag_q <= wr_vpn;
        ppn_q <= wr_ppn;
        flg_q <= wr_flags;
      end
    end
  end

  always_comb begin
    logic [3:0] f;
    lk_ppn = '0;
    f      = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      lk_ppn = lk_ppn | ppn_m[i];
      f      = f | flg_m[i];
    end
    lk_flags = pte_flags_t'(f);
  end

  // R6: fills rewrite in place, so no page number is ever cached twice
  p_single_match_r6: assert property (@(posedge clk) disable iff (rst)
    $onehot0(lk_match));

  p_flush_empties_r10: assert property (@(posedge clk) disable iff (rst)
    flush |=> (present_o == '0));

  p_inv_removes_r9: assert property (@(posedge clk) disable iff (rst)
    (inv_en && !flush) |=> ((present_o & $past(inv_hits)) == '0));
endmodule

// File: rtl/xlate_victim.sv
module xlate_victim #(
  parameter int ENTRIES = 16,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               fill_go,
  input  logic [ENTRIES-1:0] present,
  input  logic [ENTRIES-1:0] fill_match,
  output logic [IDX_W-1:0]   slot
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

  logic [IDX_W-1:0] ptr_q;
  logic [IDX_W-1:0] free_idx;
  logic [IDX_W-1:0] same_idx;
  logic             free_any;
  logic             same_any;
  logic             evict;

  always_comb begin
    free_any = 1'b0;
    free_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!present[i]) begin
        free_any = 1'b1;
        free_idx = IDX_W'(i);
      end
    end
  end

  always_comb begin
    same_idx = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (fill_match[i]) same_idx = same_idx | IDX_W'(i);
    end
  end

  assign same_any = |fill_match;
  assign evict    = fill_go && !same_any && !free_any;
  assign slot     = same_any ? same_idx : (free_any ? free_idx : ptr_q);

  always_ff @(posedge clk) begin
    if (rst)        ptr_q <= '0;
    else if (evict) ptr_q <= (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
  end

  // R8: the pointer only moves on a replacing fill
  p_ptr_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !evict |=> $stable(ptr_q));

  p_ptr_moves_r8: assert property (@(posedge clk) disable iff (rst)
    evict |=> (ptr_q != $past(ptr_q)));

  // R7: replacement happens only when no slot is empty
  p_evict_only_full_r7: assert property (@(posedge clk) disable iff (rst)
    evict |-> (&present));
endmodule

// File: rtl/xlate_cache.sv
module xlate_cache
  import xlate_pkg::*;
#(
  parameter int VA_W    = 32,
  parameter int OFF_W   = 11,
  parameter int PPN_W   = 13,
  parameter int ENTRIES = 16
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   lk_valid,
  input  logic [VA_W-1:0]        lk_vaddr,
  input  logic [1:0]             lk_kind,
  input  logic                   fill_en,
  input  logic [VA_W-OFF_W-1:0]  fill_vpn,
  input  logic [PPN_W-1:0]       fill_ppn,
  input  logic [3:0]             fill_flags,
  input  logic                   inv_en,
  input  logic [VA_W-OFF_W-1:0]  inv_vpn,
  input  logic                   flush_all,
  output logic                   rsp_valid,
  output logic                   hit,
  output logic                   miss,
  output logic                   page_fault,
  output logic                   perm_fault,
  output logic [PPN_W+OFF_W-1:0] paddr
);
  localparam int VPN_W = VA_W - OFF_W;
  localparam int IDX_W = $clog2(ENTRIES);

  logic [ENTRIES-1:0] present;
  logic [ENTRIES-1:0] lk_match;
  logic [ENTRIES-1:0] fill_match;
  logic [PPN_W-1:0]   lk_ppn;
  pte_flags_t         lk_flags;
  logic [IDX_W-1:0]   slot;
  logic               fill_go;
  logic               found;
  logic               ok;

  // R11: invalidate and flush win over a fill in the same cycle
  assign fill_go = fill_en && !inv_en && !flush_all;

  xlate_store #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PPN_W(PPN_W)) u_store (
    .clk        (clk),
    .rst        (rst),
    .flush      (flush_all),
    .inv_en     (inv_en),
    .inv_vpn    (inv_vpn),
    .wr_en      (fill_go),
    .wr_idx     (slot),
    .wr_vpn     (fill_vpn),
    .wr_ppn     (fill_ppn),
    .wr_flags   (pte_flags_t'(fill_flags)),
    .lk_vpn     (lk_vaddr[VA_W-1:OFF_W]),
    .present_o  (present),
    .lk_match   (lk_match),
    .fill_match (fill_match),
    .lk_ppn     (lk_ppn),
    .lk_flags   (lk_flags)
  );

  xlate_victim #(.ENTRIES(ENTRIES)) u_victim (
    .clk        (clk),
    .rst        (rst),
    .fill_go    (fill_go),
    .present    (present),
    .fill_match (fill_match),
    .slot       (slot)
  );

  assign found = |lk_match;
  assign ok    = kind_allowed(lk_flags, acc_kind_e'(lk_kind));

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid  <= 1'b0;
      hit        <= 1'b0;
      miss       <= 1'b0;
      page_fault <= 1'b0;
      perm_fault <= 1'b0;
      paddr      <= '0;
    end else begin
      rsp_valid  <= lk_valid;
      hit        <= lk_valid && found && lk_flags.v && ok;
      miss       <= lk_valid && !found;
      page_fault <= lk_valid && found && !lk_flags.v;
      perm_fault <= lk_valid && found && lk_flags.v && !ok;
      paddr      <= (lk_valid && found && lk_flags.v && ok) ?
                    {lk_ppn, lk_vaddr[OFF_W-1:0]} : '0;
    end
  end

  p_one_outcome_r2: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> ($countones({hit, miss, page_fault, perm_fault}) == 1));

  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    !rsp_valid |-> !(hit || miss || page_fault || perm_fault));

  p_answer_next_r2: assert property (@(posedge clk) disable iff (rst)
    lk_valid |=> rsp_valid);

  p_no_stray_answer_r2: assert property (@(posedge clk) disable iff (rst)
    !lk_valid |=> !rsp_valid);

  p_paddr_zero_r2: assert property (@(posedge clk) disable iff (rst)
    !hit |-> (paddr == '0));
endmodule

// File: tb/xlate_cache_bench.sv
`timescale 1ns/1ps
module xlate_cache_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        lk_valid = 1'b0;
  logic [31:0] lk_vaddr = '0;
  logic [1:0]  lk_kind = '0;
  logic        fill_en = 1'b0;
  logic [20:0] fill_vpn = '0;
  logic [12:0] fill_ppn = '0;
  logic [3:0]  fill_flags = '0;
  logic        inv_en = 1'b0;
  logic [20:0] inv_vpn = '0;
  logic        flush_all = 1'b0;
  logic        rsp_valid, hit, miss, page_fault, perm_fault;
  logic [23:0] paddr;

  int n_run = 0;
  int n_fail = 0;

  localparam logic [3:0] H  = 4'b1000;
  localparam logic [3:0] M  = 4'b0100;
  localparam logic [3:0] PF = 4'b0010;
  localparam logic [3:0] PM = 4'b0001;
  localparam logic [3:0] ALL = 4'b1111;

  always #2 clk = ~clk;

  xlate_cache u_xlate_cache (
    .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_vaddr(lk_vaddr), .lk_kind(lk_kind),
    .fill_en(fill_en), .fill_vpn(fill_vpn), .fill_ppn(fill_ppn), .fill_flags(fill_flags),
    .inv_en(inv_en), .inv_vpn(inv_vpn), .flush_all(flush_all),
    .rsp_valid(rsp_valid), .hit(hit), .miss(miss), .page_fault(page_fault),
    .perm_fault(perm_fault), .paddr(paddr)
  );

  task automatic chk(input string tag, input logic [28:0] act, input logic [28:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [28:0] expect_word(input logic [3:0] code, input logic [12:0] ppn,
                                             input logic [10:0] off);
    return {1'b1, code, (code == H) ? {ppn, off} : 24'h0};
  endfunction

  task automatic look(input logic [20:0] vpn, input logic [10:0] off, input logic [1:0] k,
                      input logic [3:0] code, input logic [12:0] ppn, input string tag);
    @(negedge clk);
    lk_valid = 1'b1; lk_vaddr = {vpn, off}; lk_kind = k;
    @(negedge clk);
    lk_valid = 1'b0;
    chk(tag, {rsp_valid, hit, miss, page_fault, perm_fault, paddr}, expect_word(code, ppn, off));
  endtask

  task automatic fill(input logic [20:0] vpn, input logic [12:0] ppn, input logic [3:0] fl);
    @(negedge clk);
    fill_en = 1'b1; fill_vpn = vpn; fill_ppn = ppn; fill_flags = fl;
    @(negedge clk);
    fill_en = 1'b0;
  endtask

  task automatic inval(input logic [20:0] vpn);
    @(negedge clk);
    inv_en = 1'b1; inv_vpn = vpn;
    @(negedge clk);
    inv_en = 1'b0;
  endtask

  initial begin
    #(4 * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 idle outputs after reset", {rsp_valid, hit, miss, page_fault, perm_fault, paddr}, '0);
    look(21'h100, 11'h0, 2'd0, M, '0, "R1 empty after reset");

    // R7: sixteen new pages land in slots 0..15 in order
    for (int i = 0; i < 16; i++) fill(21'h100 + 21'(i), 13'h40 + 13'(i), ALL);
    for (int i = 0; i < 16; i++)
      look(21'h100 + 21'(i), 11'((i * 37 + 5) % 2048), 2'(i % 3), H, 13'h40 + 13'(i),
           "R5 R7 hit after fill");
    look(21'h200, 11'h7ff, 2'd0, M, '0, "R3 uncached page");

    // R8: full array, pointer starts at slot 0
    fill(21'h300, 13'h0a0, ALL);
    look(21'h100, 11'h1, 2'd0, M, '0, "R8 slot0 evicted");
    look(21'h300, 11'h2, 2'd1, H, 13'h0a0, "R8 new page in slot0");
    look(21'h101, 11'h3, 2'd0, H, 13'h41, "R8 slot1 kept");
    fill(21'h301, 13'h0a1, ALL);
    look(21'h101, 11'h4, 2'd0, M, '0, "R8 slot1 evicted next");
    look(21'h102, 11'h5, 2'd0, H, 13'h42, "R8 slot2 kept");

    // R9: single invalidation
    inval(21'h105);
    look(21'h105, 11'h6, 2'd0, M, '0, "R9 removed page");
    look(21'h104, 11'h7, 2'd0, H, 13'h44, "R9 neighbour kept");
    inval(21'h999);
    look(21'h106, 11'h8, 2'd2, H, 13'h46, "R9 absent page no effect");

    // R7: hole reused, pointer still at slot 2
    fill(21'h302, 13'h0a2, ALL);
    look(21'h102, 11'h9, 2'd0, H, 13'h42, "R7 hole used, slot2 kept");
    look(21'h302, 11'ha, 2'd0, H, 13'h0a2, "R7 page in hole");
    fill(21'h303, 13'h0a3, ALL);
    look(21'h102, 11'hb, 2'd0, M, '0, "R8 slot2 evicted");
    look(21'h103, 11'hc, 2'd0, H, 13'h43, "R8 slot3 kept");

    // R4 R5 R6: every flag pattern on cached page 0x103 (slot 3), all kinds
    for (int p = 0; p < 16; p++) begin
      fill(21'h103, 13'h1000 + 13'(p), 4'(p));
      for (int k = 0; k < 4; k++) begin
        logic okk;
        logic [3:0] code;
        okk  = (k == 0) ? p[2] : (k == 1) ? p[1] : (k == 2) ? p[0] : 1'b0;
        code = !p[3] ? PF : (okk ? H : PM);
        look(21'h103, 11'(p * 100 + k), 2'(k), code, 13'h1000 + 13'(p), "R4 R5 flag sweep");
      end
    end
    look(21'h104, 11'h11, 2'd0, H, 13'h44, "R6 other slot intact");
    // R6: overwrites did not move pointer (still slot 3)
    fill(21'h304, 13'h0a4, ALL);
    look(21'h103, 11'h12, 2'd0, M, '0, "R6 pointer unmoved, slot3 evicted");
    look(21'h104, 11'h13, 2'd0, H, 13'h44, "R6 slot4 kept");

    // R12: lookup and fill at the same edge
    @(negedge clk);
    lk_valid = 1'b1; lk_vaddr = {21'h400, 11'h20}; lk_kind = 2'd0;
    fill_en = 1'b1; fill_vpn = 21'h400; fill_ppn = 13'h0b0; fill_flags = ALL;
    @(negedge clk);
    lk_valid = 1'b0; fill_en = 1'b0;
    chk("R12 lookup ahead of fill", {rsp_valid, hit, miss, page_fault, perm_fault, paddr},
        expect_word(M, '0, 11'h20));
    look(21'h400, 11'h21, 2'd0, H, 13'h0b0, "R12 fill visible later");
    @(negedge clk);
    lk_valid = 1'b1; lk_vaddr = {21'h400, 11'h22}; lk_kind = 2'd1;
    inv_en = 1'b1; inv_vpn = 21'h400;
    @(negedge clk);
    lk_valid = 1'b0; inv_en = 1'b0;
    chk("R12 lookup ahead of invalidate", {rsp_valid, hit, miss, page_fault, perm_fault, paddr},
        expect_word(H, 13'h0b0, 11'h22));
    look(21'h400, 11'h23, 2'd0, M, '0, "R9 R12 invalidate visible later");

    // R11: fill discarded under invalidate
    @(negedge clk);
    fill_en = 1'b1; fill_vpn = 21'h500; fill_ppn = 13'h0c0; fill_flags = ALL;
    inv_en = 1'b1; inv_vpn = 21'h999;
    @(negedge clk);
    fill_en = 1'b0; inv_en = 1'b0;
    look(21'h500, 11'h30, 2'd0, M, '0, "R11 fill dropped under invalidate");
    look(21'h106, 11'h31, 2'd0, H, 13'h46, "R11 array otherwise intact");

    // R10 R11: flush with a fill in the same cycle
    @(negedge clk);
    fill_en = 1'b1; fill_vpn = 21'h501; fill_ppn = 13'h0c1; fill_flags = ALL;
    flush_all = 1'b1;
    @(negedge clk);
    fill_en = 1'b0; flush_all = 1'b0;
    look(21'h501, 11'h32, 2'd0, M, '0, "R11 fill dropped under flush");
    for (int i = 0; i < 16; i++)
      look(21'h100 + 21'(i), 11'h33, 2'd0, M, '0, "R10 flushed");
    look(21'h300, 11'h34, 2'd0, M, '0, "R10 flushed replacement page");
    fill(21'h600, 13'h0d0, 4'b1010);
    look(21'h600, 11'h35, 2'd1, H, 13'h0d0, "R5 R10 usable after flush");
    look(21'h600, 11'h36, 2'd3, PM, '0, "R5 reserved kind");
    @(negedge clk);
    chk("R2 quiet without request", {rsp_valid, hit, miss, page_fault, perm_fault, paddr}, '0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule